// File: doc/BRIEF.md
# Quad-Precision Float to Signed 64-bit Integer Truncating Converter

This block takes a 128-bit binary floating-point operand and converts it to a signed 64-bit integer. It always rounds toward zero. Values outside the signed 64-bit range are clamped to the nearest representable bound. Infinities and NaNs are mapped to fixed saturation codes. The block also raises status flags that the surrounding floating-point unit gathers into its own status state.

The operand has three fields. Bit 127 is the sign. Bits 126:112 hold a 15-bit exponent biased by 16383. Bits 111:0 hold a 112-bit fraction. An exponent of all ones marks infinity when the fraction is zero and NaN when it is not. Fraction bit 111 set marks a quiet NaN.

The caller pulses `in_valid` with the operand and an invalid-trap-enable bit. Exactly one clock later, `out_valid` rises together with the 128-bit destination image, its write enable and the flags. The destination image carries the integer in bits 63:0 and zero in bits 127:64. The write is withheld when invalid traps are enabled and the conversion was invalid.

Top module: `qfp_to_i64`

## Requirements
- R1: Any NaN operand (exponent all ones, fraction nonzero) yields integer 0x8000_0000_0000_0000 and raises `flag_cvt_inv`.
- R2: `flag_snan_inv` is raised only for a signalling NaN, which is a NaN with fraction bit 111 clear. A quiet NaN leaves it low.
- R3: +infinity yields 0x7FFF_FFFF_FFFF_FFFF and -infinity yields 0x8000_0000_0000_0000. Both raise `flag_cvt_inv`.
- R4: +0 and -0 yield 0 with every flag low.
- R5: Finite values are truncated toward zero. Magnitudes below 1, including denormals (exponent field 0, fraction nonzero), yield 0. `flag_inexact` is raised exactly when nonzero fraction bits were dropped from an in-range result.
- R6: A truncated value above 2^63-1 yields 0x7FFF_FFFF_FFFF_FFFF, and one below -2^63 yields 0x8000_0000_0000_0000. Both raise `flag_cvt_inv` and leave `flag_inexact` low. A truncated value of exactly -2^63 is in range and raises no invalid flag.
- R7: When written, `dest_value[63:0]` holds the integer and `dest_value[127:64]` is zero.
- R8: `dest_wr` is low when `inv_trap_en` was 1 and either invalid flag is raised. Otherwise it equals `out_valid`. The flags are reported either way.
- R9: `flag_frac_rnd` is always 0 (truncation never increments). `flag_frac_inx` equals `flag_inexact` when no invalid flag is raised, and is 0 otherwise.
- R10: `out_valid` is high exactly one cycle after an `in_valid` cycle. While `out_valid` is low, `dest_wr` and all flags are low.
- R11: While `rst_n` is low at a clock edge, `out_valid`, `dest_wr` and all flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| operand | input | 128 | Quad-precision source |
| inv_trap_en | input | 1 | Invalid-exception enable; suppresses the write on invalid |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| dest_wr | output | 1 | Destination write enable |
| dest_value | output | 128 | Integer in bits 63:0, zero in bits 127:64 |
| flag_snan_inv | output | 1 | Signalling-NaN invalid |
| flag_cvt_inv | output | 1 | Conversion invalid |
| flag_inexact | output | 1 | Fraction bits discarded |
| flag_frac_rnd | output | 1 | Fraction rounded (magnitude incremented) |
| flag_frac_inx | output | 1 | Fraction inexact, masked by invalid |

## Verification
Most internal faults surface one cycle after the operand strobe, because every output is registered directly from the conversion logic.

A wrong exponent bias or shift amount corrupts the integer value. It also moves the boundaries at 2^63-1, exactly -2^63 and magnitude one. A mis-decoded class shows up as a wrong saturation code or a wrong invalid flag on NaN and infinity. A bad discarded-bits test shows as a wrong `flag_inexact` on values that are exactly integral.

A slip in the trap gating is visible only on `dest_wr`. Those cases are probed with the enable both set and cleared.

// File: rtl/qcvt_pkg.sv
// Package: shared operand class type for the quad-to-int64 converter.
// Assumes an IEEE-style binary interchange layout (sign, biased exponent, fraction).
package qcvt_pkg;

    typedef enum logic [2:0] {
        CL_ZERO  = 3'd0,
        CL_TINY  = 3'd1,
        CL_NORM  = 3'd2,
        CL_INF   = 3'd3,
        CL_QNAN  = 3'd4,
        CL_SNAN  = 3'd5
    } op_class_e;

endpackage

// File: rtl/qcvt_classify.sv
// Module: qcvt_classify
// Sorts a floating-point operand into zero, tiny (denormal), normal,
// infinity, quiet NaN or signalling NaN. Purely combinational.
// Assumes the top fraction bit distinguishes quiet from signalling NaN.
module qcvt_classify
    import qcvt_pkg::*;
#(
    parameter int EXP_W  = 15,
    parameter int FRAC_W = 112
) (
    input  logic [EXP_W-1:0]  exp_b,
    input  logic [FRAC_W-1:0] frac,
    output op_class_e         cls
);

    logic exp_max;
    logic exp_min;
    logic frac_nz;

    assign exp_max = &exp_b;
    assign exp_min = ~|exp_b;
    assign frac_nz = |frac;

    // Decode the class from the exponent extremes and fraction content.
    always_comb begin
        if (exp_max) begin
            if (!frac_nz)               cls = CL_INF;
            else if (frac[FRAC_W-1])    cls = CL_QNAN;
            else                        cls = CL_SNAN;
        end else if (exp_min) begin
            cls = frac_nz ? CL_TINY : CL_ZERO;
        end else begin
            cls = CL_NORM;
        end
    end

endmodule

// File: rtl/qcvt_truncate.sv
// Module: qcvt_truncate
// Truncates a classified operand toward zero into a signed integer,
// saturating out-of-range values and producing invalid/inexact flags.
// Combinational. Assumes INT_W-1 < FRAC_W so the integer part fits the
// significand shift window.
module qcvt_truncate
    import qcvt_pkg::*;
#(
    parameter int EXP_W  = 15,
    parameter int FRAC_W = 112,
    parameter int INT_W  = 64
) (
    input  logic              sign,
    input  logic [EXP_W-1:0]  exp_b,
    input  logic [FRAC_W-1:0] frac,
    input  op_class_e         cls,
    output logic [INT_W-1:0]  result,
    output logic              snan_inv,
    output logic              cvt_inv,
    output logic              inexact,
    output logic              incr
);

    localparam int MANT_W = FRAC_W + 1;
    localparam int SH_W   = $clog2(MANT_W + 1);
    localparam int E_W    = EXP_W + 2;
    localparam logic signed [E_W-1:0] BIAS_S = E_W'((1 << (EXP_W - 1)) - 1);
    localparam logic signed [E_W-1:0] FRAC_S = E_W'(FRAC_W);
    localparam logic signed [E_W-1:0] TOP_S  = E_W'(INT_W - 1);
    localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};

    logic signed [E_W-1:0] e_unb;
    logic signed [E_W-1:0] sh_full;
    logic [SH_W-1:0]       sh;
    logic [MANT_W-1:0]     mant;
    logic [MANT_W-1:0]     mag_wide;
    logic [INT_W-1:0]      mag;
    logic                  lost;
    logic                  fits;

    assign e_unb   = $signed({2'b00, exp_b}) - BIAS_S;
    assign sh_full = FRAC_S - e_unb;
    assign sh      = sh_full[SH_W-1:0];
    assign mant    = {1'b1, frac};
    assign incr    = 1'b0;

    // Align the significand so its integer part lands in the low bits.
    always_comb begin
        mag_wide = mant >> sh;
        mag      = mag_wide[INT_W-1:0];
        lost     = ((mag_wide << sh) != mant);
    end

    // Range test on the truncated magnitude; the negative side reaches one further.
    always_comb begin
        if (e_unb > TOP_S)  fits = 1'b0;
        else if (sign)      fits = !mag[INT_W-1] || (mag[INT_W-2:0] == '0);
        else                fits = !mag[INT_W-1];
    end

    // Select the result and flags per operand class.
    always_comb begin
        result   = '0;
        snan_inv = 1'b0;
        cvt_inv  = 1'b0;
        inexact  = 1'b0;
        unique case (cls)
            CL_QNAN: begin
                result  = NEG_SAT;
                cvt_inv = 1'b1;
            end
            CL_SNAN: begin
                result   = NEG_SAT;
                cvt_inv  = 1'b1;
                snan_inv = 1'b1;
            end
            CL_INF: begin
                result  = sign ? NEG_SAT : POS_SAT;
                cvt_inv = 1'b1;
            end
            CL_ZERO: begin
                result = '0;
            end
            CL_TINY: begin
                inexact = 1'b1;
            end
            CL_NORM: begin
                if (e_unb < 0) begin
                    inexact = 1'b1;
                end else if (!fits) begin
                    result  = sign ? NEG_SAT : POS_SAT;
                    cvt_inv = 1'b1;
                end else begin
                    result  = sign ? (~mag + 1'b1) : mag;
                    inexact = lost;
                end
            end
            default: begin
                result = '0;
            end
        endcase
    end

endmodule

// File: rtl/qfp_to_i64.sv
// Module: qfp_to_i64
// Top: registers one quad-to-int64 truncating conversion per in_valid,
// with a one-cycle latency. Places the integer in the low doubleword of
// the destination image and gates the write on enabled invalid traps.
// Assumes a synchronous active-low reset.
module qfp_to_i64
    import qcvt_pkg::*;
#(
    parameter int EXP_W  = 15,
    parameter int FRAC_W = 112,
    parameter int INT_W  = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [EXP_W+FRAC_W:0]       operand,
    input  logic                        inv_trap_en,
    output logic                        out_valid,
    output logic                        dest_wr,
    output logic [EXP_W+FRAC_W:0]       dest_value,
    output logic                        flag_snan_inv,
    output logic                        flag_cvt_inv,
    output logic                        flag_inexact,
    output logic                        flag_frac_rnd,
    output logic                        flag_frac_inx
);

    localparam int OP_W = EXP_W + FRAC_W + 1;

    op_class_e         cls;
    logic [INT_W-1:0]  res;
    logic              snan_c;
    logic              cvt_c;
    logic              inx_c;
    logic              incr_c;
    logic              inv_c;

    qcvt_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_class (
        .exp_b (operand[OP_W-2:FRAC_W]),
        .frac  (operand[FRAC_W-1:0]),
        .cls   (cls)
    );

    qcvt_truncate #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_trunc (
        .sign     (operand[OP_W-1]),
        .exp_b    (operand[OP_W-2:FRAC_W]),
        .frac     (operand[FRAC_W-1:0]),
        .cls      (cls),
        .result   (res),
        .snan_inv (snan_c),
        .cvt_inv  (cvt_c),
        .inexact  (inx_c),
        .incr     (incr_c)
    );

    assign inv_c = snan_c | cvt_c;

    // Capture result, strobe, write enable and flags; idle cycles clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            dest_wr       <= 1'b0;
            dest_value    <= '0;
            flag_snan_inv <= 1'b0;
            flag_cvt_inv  <= 1'b0;
            flag_inexact  <= 1'b0;
            flag_frac_rnd <= 1'b0;
            flag_frac_inx <= 1'b0;
        end else if (in_valid) begin
            out_valid     <= 1'b1;
            dest_wr       <= !(inv_trap_en && inv_c);
            dest_value    <= {{(OP_W-INT_W){1'b0}}, res};
            flag_snan_inv <= snan_c;
            flag_cvt_inv  <= cvt_c;
            flag_inexact  <= inx_c;
            flag_frac_rnd <= !inv_c && incr_c;
            flag_frac_inx <= !inv_c && inx_c;
        end else begin
            out_valid     <= 1'b0;
            dest_wr       <= 1'b0;
            flag_snan_inv <= 1'b0;
            flag_cvt_inv  <= 1'b0;
            flag_inexact  <= 1'b0;
            flag_frac_rnd <= 1'b0;
            flag_frac_inx <= 1'b0;
        end
    end

endmodule

// File: rtl/qfp_to_i64_chk.sv
// Module: qfp_to_i64_chk
// Port-level temporal checks for qfp_to_i64, attached by bind.
module qfp_to_i64_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [127:0] operand,
    input logic         inv_trap_en,
    input logic         out_valid,
    input logic         dest_wr,
    input logic [127:0] dest_value,
    input logic         flag_snan_inv,
    input logic         flag_cvt_inv,
    input logic         flag_inexact,
    input logic         flag_frac_rnd,
    input logic         flag_frac_inx
);

    // R10
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !dest_wr && !flag_cvt_inv && !flag_inexact);

    // R1
    nan_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&operand[126:112]) && (|operand[111:0]))
        |=> (dest_value[63:0] == 64'h8000_0000_0000_0000) && flag_cvt_inv);

    // R2
    snan_implies_cvt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_snan_inv |-> flag_cvt_inv);

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dest_wr |-> (dest_value[127:64] == 64'd0));

    // R8
    trap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && inv_trap_en) |=> !(dest_wr && (flag_snan_inv || flag_cvt_inv)));

    // R9
    no_round_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_frac_rnd);

    // R9
    frac_inx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_frac_inx == (flag_inexact && !flag_cvt_inv && !flag_snan_inv));

    // R6
    sat_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_cvt_inv |-> !flag_inexact);

endmodule

bind qfp_to_i64 qfp_to_i64_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .operand       (operand),
    .inv_trap_en   (inv_trap_en),
    .out_valid     (out_valid),
    .dest_wr       (dest_wr),
    .dest_value    (dest_value),
    .flag_snan_inv (flag_snan_inv),
    .flag_cvt_inv  (flag_cvt_inv),
    .flag_inexact  (flag_inexact),
    .flag_frac_rnd (flag_frac_rnd),
    .flag_frac_inx (flag_frac_inx)
);

// File: tb/test_qfp_to_i64.sv
// Directed bench for qfp_to_i64: one task per scenario, each checking its results.
module test_qfp_to_i64;

    localparam int BIAS = 16383;
    localparam logic [63:0] POS_SAT = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] NEG_SAT = 64'h8000_0000_0000_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] operand = '0;
    logic         inv_trap_en = 1'b0;
    logic         out_valid;
    logic         dest_wr;
    logic [127:0] dest_value;
    logic         flag_snan_inv;
    logic         flag_cvt_inv;
    logic         flag_inexact;
    logic         flag_frac_rnd;
    logic         flag_frac_inx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    qfp_to_i64 i_qfp_to_i64 (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .operand       (operand),
        .inv_trap_en   (inv_trap_en),
        .out_valid     (out_valid),
        .dest_wr       (dest_wr),
        .dest_value    (dest_value),
        .flag_snan_inv (flag_snan_inv),
        .flag_cvt_inv  (flag_cvt_inv),
        .flag_inexact  (flag_inexact),
        .flag_frac_rnd (flag_frac_rnd),
        .flag_frac_inx (flag_frac_inx)
    );

    function automatic logic [127:0] mkq(input logic s, input int ue, input logic [111:0] f);
        logic [14:0] eb;
        eb = 15'(ue + BIAS);
        return {s, eb, f};
    endfunction

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp_v);
        end
    endtask

    // Apply one operand, then sample the registered outputs at the following negedge.
    task automatic convert(input string req, input logic [127:0] op, input logic trap,
                           input logic [63:0] ev, input logic es, input logic ec,
                           input logic ei, input logic ew);
        @(negedge clk);
        operand     = op;
        inv_trap_en = trap;
        in_valid    = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10", {req, " out_valid"}, 128'(out_valid), 128'(1'b1));
        chk(req, "snan flag", 128'(flag_snan_inv), 128'(es));
        chk(req, "cvt flag", 128'(flag_cvt_inv), 128'(ec));
        chk(req, "inexact", 128'(flag_inexact), 128'(ei));
        chk("R9", {req, " frac_rnd"}, 128'(flag_frac_rnd), 128'(1'b0));
        chk("R9", {req, " frac_inx"}, 128'(flag_frac_inx), 128'(ei && !ec && !es));
        chk("R8", {req, " dest_wr"}, 128'(dest_wr), 128'(ew));
        chk(req, "value", dest_value, {64'd0, ev});
    endtask

    task automatic t_reset;
        chk("R11", "out_valid in reset", 128'(out_valid), 128'(1'b0));
        chk("R11", "dest_wr in reset", 128'(dest_wr), 128'(1'b0));
        chk("R11", "flags in reset", 128'({flag_snan_inv, flag_cvt_inv, flag_inexact, flag_frac_rnd, flag_frac_inx}), 128'(0));
    endtask

    task automatic t_nan;
        convert("R1", {1'b0, 15'h7FFF, 1'b1, 111'd0}, 1'b0, NEG_SAT, 1'b0, 1'b1, 1'b0, 1'b1);
        convert("R2", {1'b1, 15'h7FFF, 112'd1}, 1'b0, NEG_SAT, 1'b1, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_inf;
        convert("R3", {1'b0, 15'h7FFF, 112'd0}, 1'b0, POS_SAT, 1'b0, 1'b1, 1'b0, 1'b1);
        convert("R3", {1'b1, 15'h7FFF, 112'd0}, 1'b0, NEG_SAT, 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_zero;
        convert("R4", 128'd0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        convert("R4", {1'b1, 127'd0}, 1'b1, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_trunc;
        convert("R5", mkq(1'b0, 0, 112'd0), 1'b0, 64'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        convert("R5", mkq(1'b0, 0, {1'b1, 111'd0}), 1'b0, 64'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        convert("R5", mkq(1'b1, 1, {3'b011, 109'd0}), 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b0, 1'b1, 1'b1);
        convert("R5", mkq(1'b0, -1, 112'd0), 1'b0, 64'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        convert("R5", {1'b1, 15'd0, 112'd5}, 1'b0, 64'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        convert("R5", mkq(1'b0, 62, 112'd0), 1'b0, 64'h4000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_range;
        convert("R6", mkq(1'b0, 62, {{62{1'b1}}, 50'd0}), 1'b0, POS_SAT, 1'b0, 1'b0, 1'b0, 1'b1);
        convert("R6", mkq(1'b0, 63, 112'd0), 1'b0, POS_SAT, 1'b0, 1'b1, 1'b0, 1'b1);
        convert("R6", mkq(1'b1, 63, 112'd0), 1'b0, NEG_SAT, 1'b0, 1'b0, 1'b0, 1'b1);
        convert("R6", mkq(1'b1, 63, 112'd1 << 48), 1'b0, NEG_SAT, 1'b0, 1'b0, 1'b1, 1'b1);
        convert("R6", mkq(1'b1, 63, 112'd1 << 49), 1'b0, NEG_SAT, 1'b0, 1'b1, 1'b0, 1'b1);
        convert("R6", mkq(1'b0, 200, 112'd0), 1'b0, POS_SAT, 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_trap;
        convert("R8", {1'b0, 15'h7FFF, 112'd3}, 1'b1, NEG_SAT, 1'b1, 1'b1, 1'b0, 1'b0);
        convert("R8", mkq(1'b1, 70, 112'd0), 1'b1, NEG_SAT, 1'b0, 1'b1, 1'b0, 1'b0);
        convert("R7", mkq(1'b0, 3, {2'b01, 110'd0}), 1'b1, 64'd10, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_idle;
        @(negedge clk);
        chk("R10", "idle out_valid", 128'(out_valid), 128'(1'b0));
        chk("R10", "idle dest_wr", 128'(dest_wr), 128'(1'b0));
        chk("R10", "idle flags", 128'({flag_snan_inv, flag_cvt_inv, flag_inexact, flag_frac_inx}), 128'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_nan;
        t_idle;
        t_inf;
        t_zero;
        t_trunc;
        t_range;
        t_trap;
        t_idle;
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule